// File: doc/BRIEF.md
# Serial Audio Receive Port

This block takes bit-serial audio data into parallel words. It can run as clock master or as clock slave. As master it makes its own bit clock from the prescaled master clock `clk_i` through a 12-bit divider. It also drives a channel-select line or a frame-sync pulse. As slave it samples an external bit clock and an external channel/sync line through a synchronizer. The bit clock then acts as a clock enable inside the `clk_i` domain.

Three framing modes are offered:
- **Channel select:** a level change on the line opens a word and names its channel.
- **Sync pulse:** an active level on the line marks the first bit of a word.
- **Frameless:** a word completes every 16 bits, and an active sync level resets the alignment.

A completed word is presented right-aligned on `word_o` with a one-cycle `irq_o` strobe. Configuration is static and is applied through a reset.

Top module: `sap_rx`

## Requirements
- R1: In master mode with divider value N of 2 or more, `bclk_o` has a period of exactly 2N cycles of `clk_i`.
- R2: A divider value of 0 or 1 bypasses the divider. The master bit rate then equals the `clk_i` rate, so `lrfs_o` toggles every W cycles in channel-select mode.
- R3: With `cfg_cpol_i`=0 data is latched on the rising bit-clock edge and the line is driven on the falling edge. With `cfg_cpol_i`=1 the two edges are swapped.
- R4: `cfg_wsize_i` codes 0/1/2/3 select word lengths W of 16/20/24/32 bits. Data arrives MSB first, and the word appears in `word_o[W-1:0]` with the upper bits zero.
- R5: In channel-select mode (`cfg_fmt_i`=0), the bit latched when the decoded channel differs from that of the previous latched bit is the MSB of a new word. `chan_o` reports the channel, 0 for left and 1 for right. Bits after the W-th bit are ignored until the next change.
- R6: The decoded line level is the pin level XOR `cfg_wpol_i`. Both polarities work in every mode. On `lrfs_o`, left is driven as `cfg_wpol_i` and right as its inverse. An active sync level is driven as the inverse of `cfg_wpol_i`.
- R7: In sync-pulse mode (`cfg_fmt_i`=1), a bit latched with the sync line active is the MSB of a new word. `chan_o` is 0 in this mode.
- R8: In frameless mode (`cfg_fmt_i`=2 or 3), an irq fires after every 16 latched bits, independent of `cfg_wsize_i`, and the word holds 16 bits.
- R9: In frameless mode, a bit latched with the sync line active restarts alignment. That bit becomes the MSB of the next word, and any partial word is dropped.
- R10: As master, `lrfs_o` changes only one cycle after a drive edge. It toggles every W bits in channel-select mode and pulses active for one bit period every frame in the other modes.
- R11: Synchronous reset clears `irq_o` and `word_o` and resets both counters. After reset, `lrfs_o` shows the right channel (inverse of `cfg_wpol_i`) in channel-select mode.
- R12: `irq_o` is a single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaled master clock; all logic runs on it |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_master_i | input | 1 | 1 = generate bit clock and line, 0 = receive them |
| cfg_fmt_i | input | 2 | 0 channel select, 1 sync pulse, 2/3 frameless |
| cfg_wpol_i | input | 1 | Line polarity |
| cfg_cpol_i | input | 1 | Bit-clock edge choice |
| cfg_wsize_i | input | 2 | Word length code (16/20/24/32) |
| cfg_div_i | input | 12 | Bit-clock divider N |
| bclk_i | input | 1 | External bit clock (slave) |
| lrfs_i | input | 1 | External channel-select / sync line (slave) |
| sd_i | input | 1 | Serial data |
| bclk_o | output | 1 | Generated bit clock (master) |
| lrfs_o | output | 1 | Generated channel-select / sync line (master) |
| word_o | output | 32 | Last completed word, right-aligned |
| chan_o | output | 1 | Channel of the last word |
| irq_o | output | 1 | One-cycle word-complete strobe |

## Verification
Several properties are checked on every cycle:
- the single-cycle shape of the strobe;
- clearing by reset;
- the width bound of each delivered word for the active word length;
- the zero channel tag outside channel-select mode;
- spacing of master latch ticks when the divider is active;
- changes of `lrfs_o` happening only after a drive tick.

Other behaviour can only be shown by the bench's scenarios:
- the exact word values for every size, polarity and edge choice;
- dropping of excess bits;
- realignment by a sync pulse in frameless mode;
- the exact bit-clock and frame periods in cycles.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int DIV_W  = 12;
  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int FREE_LEN = 16;

  typedef enum logic [1:0] {
    FMT_CHSEL = 2'd0,
    FMT_SYNC  = 2'd1,
    FMT_FREE  = 2'd2,
    FMT_FREEB = 2'd3
  } fmt_e;

  function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(16);
      2'd1:    return CNT_W'(20);
      2'd2:    return CNT_W'(24);
      default: return CNT_W'(32);
    endcase
  endfunction

  function automatic logic is_free(input logic [1:0] fmt);
    return fmt[1];
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input logic [1:0] fmt,
                                                  input logic [1:0] code);
    return is_free(fmt) ? CNT_W'(FREE_LEN) : word_bits(code);
  endfunction

  function automatic logic div_bypass(input logic [DIV_W-1:0] div);
    return div <= DIV_W'(1);
  endfunction
endpackage

// File: rtl/sap_bitclk.sv
module sap_bitclk
  import sap_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          cpol_i,
  input  logic [DW-1:0] div_i,
  output logic          bclk_q_o,
  output logic          bypass_o,
  output logic          latch_tick_o,
  output logic          drive_tick_o
);
  logic [DW-1:0] cnt_q;
  logic          bclk_q;
  logic          toggle;

  assign bypass_o = (div_i <= DW'(1));
  assign toggle   = !bypass_o && (cnt_q == div_i - DW'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      bclk_q <= cpol_i;
    end else if (bypass_o) begin
      cnt_q  <= '0;
    end else if (toggle) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + DW'(1);
    end
  end

  always_comb begin
    if (bypass_o) begin
      latch_tick_o = 1'b1;
      drive_tick_o = 1'b1;
    end else begin
      latch_tick_o = toggle && (bclk_q == cpol_i);
      drive_tick_o = toggle && (bclk_q != cpol_i);
    end
  end

  assign bclk_q_o = bclk_q;
endmodule

// File: rtl/sap_framer.sv
module sap_framer
  import sap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             drive_tick_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             lr_o,
  output logic             sync_o
);
  logic [CNT_W-1:0] pos_q;
  logic             lr_q;
  logic             sync_q;
  logic             at_head;

  assign at_head = (pos_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pos_q  <= '0;
      lr_q   <= 1'b1;
      sync_q <= 1'b0;
    end else if (drive_tick_i) begin
      sync_q <= at_head;
      if (at_head) lr_q <= ~lr_q;
      pos_q  <= (pos_q == len_i - CNT_W'(1)) ? '0 : pos_q + CNT_W'(1);
    end
  end

  assign lr_o   = lr_q;
  assign sync_o = sync_q;
endmodule

// File: rtl/sap_pin_sync.sv
module sap_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cpol_i,
  input  logic bclk_i,
  input  logic lrfs_i,
  input  logic sd_i,
  output logic latch_tick_o,
  output logic lrfs_o,
  output logic sd_o
);
  localparam int LAST = STAGES - 1;
  logic [2:0] pipe_q [STAGES];
  logic       prev_q;
  logic       cur;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      prev_q <= 1'b0;
    end else begin
      pipe_q[0] <= {bclk_i, lrfs_i, sd_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      prev_q <= pipe_q[LAST][2];
    end
  end

  assign cur          = pipe_q[LAST][2];
  assign latch_tick_o = cpol_i ? (prev_q && !cur) : (!prev_q && cur);
  assign lrfs_o       = pipe_q[LAST][1];
  assign sd_o         = pipe_q[LAST][0];
endmodule

// File: rtl/sap_deser.sv
module sap_deser
  import sap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic              sd_i,
  input  logic              line_i,
  input  logic [1:0]        fmt_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              start_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              chan_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] sr_q, next_sr, word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, seen_q, prev_q, cur_ch_q, chan_q, irq_q;
  logic              start_c;

  always_comb begin
    if (is_free(fmt_i))             start_c = line_i || !busy_q;
    else if (fmt_i == FMT_CHSEL)    start_c = seen_q && (line_i != prev_q);
    else                            start_c = line_i;
    next_sr = start_c ? {{(WORD_W-1){1'b0}}, sd_i} : {sr_q[WORD_W-2:0], sd_i};
  end

  assign start_o = tick_i && start_c;
  assign done_o  = tick_i && !start_c && busy_q && (cnt_q + CNT_W'(1) == len_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      seen_q   <= 1'b0;
      prev_q   <= 1'b0;
      cur_ch_q <= 1'b0;
      word_q   <= '0;
      chan_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= done_o;
      if (done_o) begin
        word_q <= next_sr;
        chan_q <= cur_ch_q;
      end
      if (tick_i) begin
        prev_q <= line_i;
        seen_q <= 1'b1;
        if (start_c) begin
          sr_q     <= next_sr;
          cnt_q    <= CNT_W'(1);
          busy_q   <= 1'b1;
          cur_ch_q <= (fmt_i == FMT_CHSEL) ? line_i : 1'b0;
        end else if (busy_q) begin
          sr_q  <= next_sr;
          cnt_q <= cnt_q + CNT_W'(1);
          if (done_o) busy_q <= 1'b0;
        end
      end
    end
  end

  assign word_o = word_q;
  assign chan_o = chan_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/sap_rx.sv
module sap_rx
  import sap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cfg_master_i,
  input  logic [1:0]        cfg_fmt_i,
  input  logic              cfg_wpol_i,
  input  logic              cfg_cpol_i,
  input  logic [1:0]        cfg_wsize_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic              bclk_i,
  input  logic              lrfs_i,
  input  logic              sd_i,
  output logic              bclk_o,
  output logic              lrfs_o,
  output logic [WORD_W-1:0] word_o,
  output logic              chan_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] len;
  logic gen_bclk, bypass, gen_latch, gen_drive;
  logic syn_latch, syn_line, syn_sd;
  logic fr_lr, fr_sync, fr_state;
  logic latch_tick, drive_tick, line, data;
  logic word_start, word_done;

  assign len = frame_len(cfg_fmt_i, cfg_wsize_i);

  sap_bitclk #(.DW(DIV_W)) u_clk (
    .clk_i(clk_i), .rst_i(rst_i), .cpol_i(cfg_cpol_i), .div_i(cfg_div_i),
    .bclk_q_o(gen_bclk), .bypass_o(bypass),
    .latch_tick_o(gen_latch), .drive_tick_o(gen_drive)
  );

  sap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .cpol_i(cfg_cpol_i),
    .bclk_i(bclk_i), .lrfs_i(lrfs_i), .sd_i(sd_i),
    .latch_tick_o(syn_latch), .lrfs_o(syn_line), .sd_o(syn_sd)
  );

  assign drive_tick = cfg_master_i && gen_drive;
  assign latch_tick = cfg_master_i ? gen_latch : syn_latch;

  sap_framer u_frm (
    .clk_i(clk_i), .rst_i(rst_i), .drive_tick_i(drive_tick), .len_i(len),
    .lr_o(fr_lr), .sync_o(fr_sync)
  );

  assign fr_state = (cfg_fmt_i == FMT_CHSEL) ? fr_lr : fr_sync;
  assign line     = cfg_master_i ? fr_state : (syn_line ^ cfg_wpol_i);
  assign data     = cfg_master_i ? sd_i : syn_sd;

  sap_deser u_des (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(latch_tick), .sd_i(data),
    .line_i(line), .fmt_i(cfg_fmt_i), .len_i(len),
    .start_o(word_start), .done_o(word_done),
    .word_o(word_o), .chan_o(chan_o), .irq_o(irq_o)
  );

  assign bclk_o = (cfg_master_i && bypass) ? clk_i : gen_bclk;
  assign lrfs_o = fr_state ^ cfg_wpol_i;
endmodule

// File: rtl/sap_rx_chk.sv
module sap_rx_chk
  import sap_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic              cfg_master_i,
  input logic [1:0]        cfg_fmt_i,
  input logic              cfg_wpol_i,
  input logic [1:0]        cfg_wsize_i,
  input logic [DIV_W-1:0]  cfg_div_i,
  input logic              lrfs_o,
  input logic [WORD_W-1:0] word_o,
  input logic              chan_o,
  input logic              irq_o,
  input logic              latch_tick,
  input logic              drive_tick
);
  logic [63:0] lim;
  assign lim = 64'(1) << frame_len(cfg_fmt_i, cfg_wsize_i);

  a_r12_single_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |=> !irq_o);

  a_r11_reset_clears: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!irq_o && word_o == '0));

  a_r4_word_fits: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> (64'(word_o) < lim));

  a_r8_free_16: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_o && is_free(cfg_fmt_i)) |-> (word_o[WORD_W-1:16] == '0));

  a_r7_no_chan_tag: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_o && cfg_fmt_i != FMT_CHSEL) |-> !chan_o);

  a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg_master_i && cfg_div_i >= DIV_W'(2) && $stable(cfg_div_i) && latch_tick)
      |=> !latch_tick);

  a_r10_line_on_drive: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $stable(cfg_wpol_i) && $stable(cfg_fmt_i) && !$stable(lrfs_o))
      |-> $past(drive_tick));
endmodule

bind sap_rx sap_rx_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .cfg_master_i(cfg_master_i),
  .cfg_fmt_i(cfg_fmt_i), .cfg_wpol_i(cfg_wpol_i), .cfg_wsize_i(cfg_wsize_i),
  .cfg_div_i(cfg_div_i), .lrfs_o(lrfs_o), .word_o(word_o), .chan_o(chan_o),
  .irq_o(irq_o), .latch_tick(latch_tick), .drive_tick(drive_tick)
);

// File: tb/sap_rx_test.sv
module sap_rx_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, master = 1'b0, wpol = 1'b0, cpol = 1'b0;
  logic [1:0]  fmt = 2'd0, wsize = 2'd0;
  logic [11:0] div = 12'd2;
  logic        bclk_i = 1'b0, lrfs_i = 1'b0, sd_i = 1'b0;
  logic        bclk_o, lrfs_o, chan_o, irq_o;
  logic [31:0] word_o;

  sap_rx uut (
    .clk_i(clk), .rst_i(rst), .cfg_master_i(master), .cfg_fmt_i(fmt),
    .cfg_wpol_i(wpol), .cfg_cpol_i(cpol), .cfg_wsize_i(wsize), .cfg_div_i(div),
    .bclk_i(bclk_i), .lrfs_i(lrfs_i), .sd_i(sd_i),
    .bclk_o(bclk_o), .lrfs_o(lrfs_o), .word_o(word_o), .chan_o(chan_o), .irq_o(irq_o)
  );

  int errors = 0, checks = 0;
  logic [31:0] cap_w [64];
  logic        cap_c [64];
  int          ncap;

  always @(negedge clk) begin
    if (rst) ncap <= 0;
    else if (irq_o && ncap < 64) begin
      cap_w[ncap] <= word_o;
      cap_c[ncap] <= chan_o;
      ncap <= ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bclk_i = cpol;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sbit(input logic ln, input logic d);
    bclk_i = cpol; lrfs_i = ln; sd_i = d;
    repeat (4) @(negedge clk);
    bclk_i = ~cpol;
    repeat (4) @(negedge clk);
  endtask

  function automatic int wlen(input int code);
    return (code == 3) ? 32 : 16 + 4 * code;
  endfunction

  function automatic logic [31:0] msk(input logic [31:0] v, input int w);
    return v & 32'((64'h1 << w) - 1);
  endfunction

  task automatic measure_line(output int gap);
    logic pv;
    int n;
    pv = lrfs_o; n = 0;
    while (lrfs_o == pv && n < 4000) begin @(negedge clk); n++; end
    pv = lrfs_o; n = 0;
    while (lrfs_o == pv && n < 4000) begin @(negedge clk); n++; end
    gap = n;
  endtask

  task automatic measure_bclk(output int per);
    logic pv;
    int n;
    n = 0; pv = bclk_o;
    while (!(pv == 1'b0 && bclk_o == 1'b1) && n < 4000) begin pv = bclk_o; @(negedge clk); n++; end
    n = 0; pv = bclk_o;
    @(negedge clk); n = 1;
    while (!(pv == 1'b0 && bclk_o == 1'b1) && n < 4000) begin pv = bclk_o; @(negedge clk); n++; end
    per = n;
  endtask

  // master sync-mode data driver
  logic        drv_en = 1'b0;
  logic [31:0] drv_pat = '0;
  int          drv_w = 24;
  int          drv_idx = 63;
  logic        drv_prev = 1'b0;
  always @(negedge clk) begin
    if (drv_en) begin
      if (drv_prev && !bclk_o) begin
        if (lrfs_o == ~wpol) drv_idx = 0; else drv_idx = drv_idx + 1;
        sd_i <= (drv_idx < drv_w) ? drv_pat[drv_w-1-drv_idx] : 1'b0;
      end
      drv_prev = bclk_o;
    end
  end

  bit finished = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, x, y, z;
    int w, g, k;
    // R11: reset state as master in channel-select mode
    master = 1'b1; fmt = 2'd0; wpol = 1'b0; div = 12'd2;
    do_reset();
    @(negedge clk);
    chk(irq_o == 1'b0, "R11 irq after reset", irq_o, 0);
    chk(word_o == 32'd0, "R11 word after reset", word_o, 0);
    chk(lrfs_o == 1'b1, "R11 line shows right", lrfs_o, 1);

    // R1/R2/R10: master timing sweep
    foreach (div[i]) ; // no-op keeps layout simple
    for (int d = 0; d < 6; d++) begin
      int dv;
      dv = (d == 0) ? 0 : (d == 1) ? 1 : (d == 2) ? 2 : (d == 3) ? 3 : (d == 4) ? 7 : 12;
      div = 12'(dv); master = 1'b1; fmt = 2'd0; wsize = 2'd0; cpol = 1'b0;
      do_reset();
      measure_line(g);
      if (dv <= 1) chk(g == 16, "R2 bypass line toggle", g, 16);
      else begin
        chk(g == 16 * 2 * dv, "R10 line toggle per frame", g, 16 * 2 * dv);
        measure_bclk(g);
        chk(g == 2 * dv, "R1 bit clock period", g, 2 * dv);
      end
    end

    // R3/R4/R5/R6: slave channel-select sweep
    k = 0;
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 4; s++) begin
          master = 1'b0; fmt = 2'd0; wpol = p[0]; cpol = c[0]; wsize = 2'(s);
          w = wlen(s); k++;
          a = msk(32'h9E3779B9 * k, w);
          b = msk(~(32'h7F4A7C15 * k), w);
          do_reset();
          sbit(1'b1 ^ wpol, 1'b0);
          for (int i = 0; i < w + 3; i++) sbit(1'b0 ^ wpol, (i < w) ? a[w-1-i] : 1'b1);
          for (int i = 0; i < w; i++) sbit(1'b1 ^ wpol, b[w-1-i]);
          repeat (16) @(negedge clk);
          chk(ncap == 2, "R5 word count", ncap, 2);
          chk(cap_w[0] == a && cap_c[0] == 1'b0, "R4 R3 R6 left word", cap_w[0], a);
          chk(cap_w[1] == b && cap_c[1] == 1'b1, "R5 R3 R6 right word", cap_w[1], b);
        end

    // R7/R6: slave sync-pulse mode
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 4; s++) begin
        master = 1'b0; fmt = 2'd1; wpol = p[0]; cpol = 1'b0; wsize = 2'(s);
        w = wlen(s); k++;
        a = msk(32'hC2B2AE35 * k, w);
        b = msk(32'h165667B1 * k + 32'h55, w);
        do_reset();
        sbit(wpol, 1'b1);
        for (int i = 0; i < w; i++) sbit((i == 0) ? ~wpol : wpol, a[w-1-i]);
        sbit(wpol, 1'b1); sbit(wpol, 1'b0);
        for (int i = 0; i < w; i++) sbit((i == 0) ? ~wpol : wpol, b[w-1-i]);
        repeat (16) @(negedge clk);
        chk(ncap == 2, "R7 word count", ncap, 2);
        chk(cap_w[0] == a && cap_c[0] == 1'b0, "R7 first word", cap_w[0], a);
        chk(cap_w[1] == b && cap_c[1] == 1'b0, "R7 second word", cap_w[1], b);
      end

    // R8/R9: frameless slave
    master = 1'b0; fmt = 2'd2; wpol = 1'b0; cpol = 1'b0; wsize = 2'd3;
    x = 32'h000B_D5A3; y = 32'h0000_6E19; z = 32'h0000_F00D;
    do_reset();
    for (int i = 0; i < 20; i++) sbit(1'b0, x[19-i]);
    for (int i = 0; i < 16; i++) sbit(i == 0, y[15-i]);
    for (int i = 0; i < 16; i++) sbit(1'b0, z[15-i]);
    repeat (16) @(negedge clk);
    chk(ncap == 3, "R8 frameless word count", ncap, 3);
    chk(cap_w[0] == x[19:4], "R8 frameless 16-bit word", cap_w[0], x[19:4]);
    chk(cap_w[1] == y, "R9 sync realigns", cap_w[1], y);
    chk(cap_w[2] == z, "R8 continuous next word", cap_w[2], z);

    // R10/R6/R7: master sync-pulse receive with inverted polarity
    master = 1'b1; fmt = 2'd1; wpol = 1'b1; cpol = 1'b0; wsize = 2'd2; div = 12'd2;
    drv_pat = 32'h00C3_5A96; drv_w = 24; drv_idx = 63; drv_prev = 1'b0; sd_i = 1'b0;
    do_reset();
    drv_en = 1'b1;
    repeat (24 * 4 * 2 + 40) @(negedge clk);
    drv_en = 1'b0;
    chk(ncap >= 2, "R7 master word count", ncap, 2);
    chk(cap_w[0] == drv_pat, "R10 master first word", cap_w[0], drv_pat);
    chk(cap_w[1] == drv_pat, "R10 master second word", cap_w[1], drv_pat);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule